// File: doc/BRIEF.md
# Dual-Set Receive DMA Channel

This block takes received Ethernet-style frames as a byte stream with an end-of-frame marker and stores each one into a fixed-size buffer slot in system memory. Each slot holds a small header, written after the frame ends, and the frame data. The header carries the stored length and a status byte.

The channel has two register sets. Each set has a base address, a count of remaining slots and a command word. The channel fills slots from the active set. When that set's count reaches zero, it disarms the set and moves to the other one. Host software can therefore reload the exhausted set while the other set takes new frames. A channel-wide control/status register lets the host hold the channel in reset and reports done and error conditions. A level interrupt tells the host when there is work to do.

Top module: `rxdma_pingpong`

## Requirements
- R1: After reset the channel is held in channel reset. The control register at 0x20 reads 0x8000, irq is 0, in_ready is 1, no memory write occurs and no set is armed.
- R2: The two sets sit at offsets 0x00 and 0x10. Within a set, the base address is at +0x0, the remaining count at +0x4 and the command word at +0x8. Base and count read back as written.
- R3: A set's command word controls arming. Writing 0x9800 arms the set and writing 0x1100 disarms it. Reading the command word shows armed in bit 15 and done in bit 8.
- R4: A control write with bit 15 set (for example 0x8800) puts the channel in reset. In reset, arm commands are ignored and incoming frames are discarded without memory writes or error. A control write with bit 15 clear (for example 0x0400) releases the channel.
- R5: Data byte n of a frame goes to base + slot*2048 + 16 + n, where slot = 8 − remaining count of the active set. A frame of L stored bytes causes exactly L + 2 memory writes.
- R6: After the data, the channel writes the header. The byte at slot+0 is length[7:0]. The byte at slot+1 has length[11:8] in bits 3:0 and the truncation flag in bit 4; other bits are 0.
- R7: Each stored frame decrements the active set's remaining count by one and sets that set's done bit.
- R8: When a set's count reaches zero, the set disarms and the active set toggles. The active set is reported in control register bit 0.
- R9: A frame that arrives while the active set is unarmed or has a zero count is discarded without memory writes. It sets the error bit (control bit 13).
- R10: A frame longer than 2032 data bytes is cut to 2032 stored bytes. Its header reports length 2032 with the truncation flag set, and the error bit is set. No write leaves the slot.
- R11: irq is high while any set's done bit or the error bit is set. Writing 0x0100 to a set's command word clears that set's done bit and the error bit.
- R12: in_ready is low for the two cycles in which the header is written after a stored frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| in_valid | input | 1 | Received byte valid |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_ready | output | 1 | Channel can accept a byte |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench sends random-length frames through both sets, past the point where each set runs out. The host model reloads each set as a driver would. A wrong slot formula would misplace data, and a missing switchover would drop frames into a disarmed set. Directed frames cover these cases:
- Lengths of 1, 300 and exactly 2032 bytes check the header nibble and the byte order.
- A 2100-byte frame checks that truncation stops inside the slot and reports the flag. A bad cutoff would write into the next slot.
- Frames sent during channel reset and to stopped sets must leave memory untouched. Frames to stopped sets must also raise the error bit, so a design that leaks writes or stays silent is caught.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [2:0] {W_IDLE, W_DATA, W_DROP, W_HDR0, W_HDR1} wr_state_e;
  localparam logic [15:0] CMD_ARM  = 16'h9800;
  localparam logic [15:0] CMD_STOP = 16'h1100;
  localparam logic [15:0] CMD_CLR  = 16'h0100;
  localparam logic [3:0]  OFF_BASE = 4'h0;
  localparam logic [3:0]  OFF_CNT  = 4'h4;
  localparam logic [3:0]  OFF_CMD  = 4'h8;
  localparam logic [7:0]  CTRL_ADDR = 8'h20;
  localparam int NSETS = 2;
endpackage

// File: rtl/rxdma_regset.sv
module rxdma_regset import rxdma_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_rst,
  input  logic              wr_base,
  input  logic              wr_cnt,
  input  logic              wr_cmd,
  input  logic [31:0]       wdata,
  input  logic              consume,
  output logic [ADDR_W-1:0] base,
  output logic [CNT_W-1:0]  count,
  output logic              armed,
  output logic              done
);
  logic [ADDR_W-1:0] base_n;
  logic [CNT_W-1:0]  cnt_n;
  logic              arm_n, done_n, en;

  assign en = consume | wr_base | wr_cnt | wr_cmd | chan_rst;

  always_comb begin
    base_n = base;
    cnt_n  = count;
    arm_n  = armed;
    done_n = done;
    if (consume) begin
      cnt_n  = count - CNT_W'(1);
      done_n = 1'b1;
      if (count == CNT_W'(1)) arm_n = 1'b0;
    end
    if (wr_base) base_n = wdata[ADDR_W-1:0];
    if (wr_cnt)  cnt_n  = wdata[CNT_W-1:0];
    if (wr_cmd) begin
      if (wdata[15:0] == CMD_ARM)       arm_n  = 1'b1;
      else if (wdata[15:0] == CMD_STOP) arm_n  = 1'b0;
      else if (wdata[15:0] == CMD_CLR)  done_n = 1'b0;
    end
    if (chan_rst) begin
      arm_n  = 1'b0;
      done_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base  <= '0;
      count <= '0;
      armed <= 1'b0;
      done  <= 1'b0;
    end else if (en) begin
      base  <= base_n;
      count <= cnt_n;
      armed <= arm_n;
      done  <= done_n;
    end
  end

  AST_ARM_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> !armed); // R4
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !wr_cnt && !chan_rst) |=> count == CNT_W'($past(count) - CNT_W'(1))); // R7
endmodule

// File: rtl/rxdma_writer.sv
module rxdma_writer import rxdma_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int SLOT_BYTES = 2048,
  parameter int HDR_BYTES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              set_ok,
  input  logic [ADDR_W-1:0] slot_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              consume,
  output logic              frame_err
);
  localparam int CAP   = SLOT_BYTES - HDR_BYTES;
  localparam int LEN_W = $clog2(SLOT_BYTES) + 1;

  wr_state_e         state, state_n;
  logic [LEN_W-1:0]  len, len_n;
  logic              trunc, trunc_n;
  logic [ADDR_W-1:0] slot_q, slot_n, addr_n;
  logic [7:0]        wd_n;
  logic              we_n, take;
  logic [11:0]       len12;

  assign in_ready = (state == W_IDLE) || (state == W_DATA) || (state == W_DROP);
  assign take     = in_valid && in_ready;
  assign len12    = 12'(len);

  always_comb begin
    state_n   = state;
    len_n     = len;
    trunc_n   = trunc;
    slot_n    = slot_q;
    we_n      = 1'b0;
    addr_n    = mem_addr;
    wd_n      = mem_wdata;
    consume   = 1'b0;
    frame_err = 1'b0;
    case (state)
      W_IDLE: if (take) begin
        if (chan_rst) begin
          state_n = in_last ? W_IDLE : W_DROP;
        end else if (set_ok) begin
          slot_n  = slot_addr;
          we_n    = 1'b1;
          addr_n  = slot_addr + ADDR_W'(HDR_BYTES);
          wd_n    = in_data;
          len_n   = LEN_W'(1);
          trunc_n = 1'b0;
          state_n = in_last ? W_HDR0 : W_DATA;
        end else begin
          frame_err = 1'b1;
          state_n   = in_last ? W_IDLE : W_DROP;
        end
      end
      W_DATA: begin
        if (chan_rst) begin
          state_n = W_IDLE;
        end else if (take) begin
          if (len < LEN_W'(CAP)) begin
            we_n   = 1'b1;
            addr_n = slot_q + ADDR_W'(HDR_BYTES) + ADDR_W'(len);
            wd_n   = in_data;
            len_n  = len + LEN_W'(1);
          end else begin
            trunc_n = 1'b1;
          end
          if (in_last) state_n = W_HDR0;
        end
      end
      W_DROP: if (take && in_last) state_n = W_IDLE;
      W_HDR0: begin
        if (chan_rst) state_n = W_IDLE;
        else begin
          we_n    = 1'b1;
          addr_n  = slot_q;
          wd_n    = len12[7:0];
          state_n = W_HDR1;
        end
      end
      W_HDR1: begin
        state_n = W_IDLE;
        if (!chan_rst) begin
          we_n      = 1'b1;
          addr_n    = slot_q + ADDR_W'(1);
          wd_n      = {3'b000, trunc, len12[11:8]};
          consume   = 1'b1;
          frame_err = trunc;
        end
      end
      default: state_n = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= W_IDLE;
      len       <= '0;
      trunc     <= 1'b0;
      slot_q    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      state  <= state_n;
      len    <= len_n;
      trunc  <= trunc_n;
      slot_q <= slot_n;
      mem_we <= we_n;
      if (we_n) begin
        mem_addr  <= addr_n;
        mem_wdata <= wd_n;
      end
    end
  end

  AST_STAY_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr - slot_q) < ADDR_W'(SLOT_BYTES)); // R10
endmodule

// File: rtl/rxdma_pingpong.sv
module rxdma_pingpong import rxdma_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int SLOT_BYTES = 2048,
  parameter int HDR_BYTES  = 16,
  parameter int NBUF       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              irq
);
  localparam int CNT_W   = $clog2(NBUF + 1);
  localparam int SLOT_LG = $clog2(SLOT_BYTES);

  logic [1:0] rsync;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign srst_n = rsync[1];

  logic              chan_rst, chan_rst_n, err, err_n, active, active_n;
  logic              wr_ctrl, clr_any, consume, frame_err, set_ok;
  logic [ADDR_W-1:0] base_a [NSETS];
  logic [CNT_W-1:0]  count_a [NSETS];
  logic [NSETS-1:0]  armed_v, done_v, wr_base_v, wr_cnt_v, wr_cmd_v, cons_v;
  logic [CNT_W-1:0]  cnt_act, used_slots;
  logic [ADDR_W-1:0] slot_addr;

  assign wr_ctrl = reg_we && (reg_addr == CTRL_ADDR);

  for (genvar gi = 0; gi < NSETS; gi++) begin : g_set
    logic hit;
    assign hit          = reg_we && (reg_addr[7:5] == 3'b000) && (reg_addr[4] == gi[0]);
    assign wr_base_v[gi] = hit && (reg_addr[3:0] == OFF_BASE);
    assign wr_cnt_v[gi]  = hit && (reg_addr[3:0] == OFF_CNT);
    assign wr_cmd_v[gi]  = hit && (reg_addr[3:0] == OFF_CMD);
    assign cons_v[gi]    = consume && (active == gi[0]);
    rxdma_regset #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_set (
      .clk(clk), .rst_n(srst_n), .chan_rst(chan_rst),
      .wr_base(wr_base_v[gi]), .wr_cnt(wr_cnt_v[gi]), .wr_cmd(wr_cmd_v[gi]),
      .wdata(reg_wdata), .consume(cons_v[gi]),
      .base(base_a[gi]), .count(count_a[gi]), .armed(armed_v[gi]), .done(done_v[gi]));
  end

  assign clr_any    = (|wr_cmd_v) && (reg_wdata[15:0] == CMD_CLR);
  assign cnt_act    = count_a[active];
  assign used_slots = CNT_W'(NBUF) - cnt_act;
  assign slot_addr  = base_a[active] + (ADDR_W'(used_slots) << SLOT_LG);
  assign set_ok     = armed_v[active] && (cnt_act != '0);
  assign irq        = (|done_v) | err;

  always_comb begin
    chan_rst_n = wr_ctrl ? reg_wdata[15] : chan_rst;
    err_n      = err;
    active_n   = active;
    if (frame_err) err_n = 1'b1;
    if (clr_any)   err_n = 1'b0;
    if (consume && (cnt_act == CNT_W'(1))) active_n = ~active;
    if (wr_ctrl && reg_wdata[15]) begin
      err_n    = 1'b0;
      active_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      chan_rst <= 1'b1;
      err      <= 1'b0;
      active   <= 1'b0;
    end else begin
      chan_rst <= chan_rst_n;
      err      <= err_n;
      active   <= active_n;
    end
  end

  rxdma_writer #(.ADDR_W(ADDR_W), .SLOT_BYTES(SLOT_BYTES), .HDR_BYTES(HDR_BYTES)) u_wr (
    .clk(clk), .rst_n(srst_n), .chan_rst(chan_rst),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .set_ok(set_ok), .slot_addr(slot_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .consume(consume), .frame_err(frame_err));

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_ADDR) begin
      reg_rdata[15] = chan_rst;
      reg_rdata[13] = err;
      reg_rdata[8]  = |done_v;
      reg_rdata[0]  = active;
    end else if (reg_addr[7:5] == 3'b000) begin
      case (reg_addr[3:0])
        OFF_BASE: reg_rdata = 32'(base_a[reg_addr[4]]);
        OFF_CNT:  reg_rdata = 32'(count_a[reg_addr[4]]);
        OFF_CMD:  begin
          reg_rdata[15] = armed_v[reg_addr[4]];
          reg_rdata[8]  = done_v[reg_addr[4]];
        end
        default:  reg_rdata = '0;
      endcase
    end
  end

  AST_SET_SWITCH: assert property (@(posedge clk) disable iff (!srst_n)
    (consume && cnt_act == CNT_W'(1) && !wr_ctrl) |=> active != $past(active)); // R8
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!srst_n)
    (chan_rst && $past(chan_rst)) |-> !mem_we); // R4
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (irq && !clr_any && !wr_ctrl) |=> irq); // R11
endmodule

// File: tb/sim_rxdma_pingpong.sv
module sim_rxdma_pingpong;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        in_valid, in_last, in_ready;
  logic [7:0]  in_data;
  logic        mem_we, irq;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxdma_pingpong u0 (.*);

  int vectors = 0, miscompares = 0, wcount = 0;
  bit finished = 0;
  bit [7:0] mem [bit [31:0]];
  logic [7:0] fbuf [0:2199];
  int exp_cnt [2];
  bit exp_arm [2];
  int exp_act;
  logic [31:0] base_v [2];

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      mem[mem_addr] = mem_wdata;
      wcount++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rdmem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic send(input int n, input bit stored);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = fbuf[i]; in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    if (stored) chk("R12 in_ready low during header", {31'b0, in_ready}, 32'd0);
  endtask

  task automatic run_frame(input int n);
    int w0, store, a, sb, bad;
    bit ok, tr;
    logic [31:0] d;
    for (int i = 0; i < n; i++) fbuf[i] = 8'($urandom);
    w0 = wcount;
    store = (n > 2032) ? 2032 : n;
    tr = (n > 2032);
    a = exp_act;
    ok = exp_arm[a] && (exp_cnt[a] != 0);
    sb = base_v[a] + (8 - exp_cnt[a]) * 2048;
    send(n, ok);
    repeat (5) @(negedge clk);
    #1;
    if (ok) begin
      chk("R6 header length low", {24'b0, rdmem(sb)}, store & 32'hFF);
      chk("R6/R10 header status", {24'b0, rdmem(sb + 1)}, {27'b0, tr, 4'((store >> 8) & 15)});
      bad = 0;
      for (int i = 0; i < store; i++) if (rdmem(sb + 16 + i) !== fbuf[i]) bad++;
      chk("R5 data bytes at slot offset", bad, 0);
      chk("R5/R10 write count", wcount - w0, store + 2);
      exp_cnt[a]--;
      rd(8'(a * 16 + 4), d);
      chk("R7 count decremented", d, exp_cnt[a]);
      rd(8'(a * 16 + 8), d);
      chk("R7 done bit", {31'b0, d[8]}, 1);
      if (exp_cnt[a] == 0) begin
        chk("R8 exhausted set disarmed", {31'b0, d[15]}, 0);
        exp_arm[a] = 0;
        exp_act ^= 1;
      end
      rd(8'h20, d);
      chk("R8 active set", {31'b0, d[0]}, exp_act);
      chk("R10 error bit after truncation", {31'b0, d[13]}, tr);
      chk("R11 irq after frame", {31'b0, irq}, 1);
    end else begin
      chk("R9 dropped frame writes", wcount - w0, 0);
      rd(8'h20, d);
      chk("R9 error bit on drop", {31'b0, d[13]}, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int w0, n;
    void'($urandom(32'd2024));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd(8'h20, d);  chk("R1 control after reset", d, 32'h8000);
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 in_ready after reset", {31'b0, in_ready}, 1);
    chk("R1 no writes in reset", wcount, 0);
    rd(8'h08, d);  chk("R1 set0 not armed", d, 0);
    // R2 register map
    base_v[0] = 32'h0001_0000; base_v[1] = 32'h0002_0000;
    wr(8'h00, base_v[0]); wr(8'h10, base_v[1]);
    wr(8'h04, 8); wr(8'h14, 8);
    exp_cnt[0] = 8; exp_cnt[1] = 8; exp_act = 0; exp_arm[0] = 0; exp_arm[1] = 0;
    rd(8'h00, d);  chk("R2 base0 readback", d, base_v[0]);
    rd(8'h10, d);  chk("R2 base1 readback", d, base_v[1]);
    rd(8'h14, d);  chk("R2 count1 readback", d, 8);
    // R4 arm ignored in channel reset, frame discarded silently
    wr(8'h20, 32'h8800);
    wr(8'h08, 32'h9800);
    rd(8'h08, d);  chk("R4 arm ignored in reset", d, 0);
    w0 = wcount;
    for (int i = 0; i < 10; i++) fbuf[i] = 8'(i);
    send(10, 0);
    repeat (4) @(negedge clk); #1;
    chk("R4 no writes in reset", wcount - w0, 0);
    rd(8'h20, d);  chk("R4 no error in reset", d, 32'h8000);
    wr(8'h20, 32'h0400);
    rd(8'h20, d);  chk("R4 released", d, 0);
    // R9 frame with nothing armed
    run_frame(12);
    chk("R11 irq on error", {31'b0, irq}, 1);
    wr(8'h08, 32'h0100);
    rd(8'h20, d);  chk("R11 error cleared", {31'b0, d[13]}, 0);
    chk("R11 irq low after clear", {31'b0, irq}, 0);
    // R3 arm both sets
    wr(8'h08, 32'h9800); wr(8'h18, 32'h9800);
    exp_arm[0] = 1; exp_arm[1] = 1;
    rd(8'h08, d);  chk("R3 set0 armed", d, 32'h8000);
    rd(8'h18, d);  chk("R3 set1 armed", d, 32'h8000);
    // Random and directed frames through both sets with host reloads
    for (int f = 0; f < 20; f++) begin
      if (f == 3)       n = 1;
      else if (f == 5)  n = 300;
      else if (f == 12) n = 2032;
      else              n = $urandom_range(2, 150);
      run_frame(n);
      for (int s = 0; s < 2; s++) begin
        if (exp_cnt[s] == 0 && s != exp_act) begin
          wr(8'(s * 16 + 4), 8); wr(8'(s * 16 + 8), 32'h9800);
          exp_cnt[s] = 8; exp_arm[s] = 1;
        end
      end
    end
    // R10 oversize frame
    run_frame(2100);
    // R11 clear both sets and the error
    wr(8'h08, 32'h0100); wr(8'h18, 32'h0100);
    chk("R11 irq low after clearing both", {31'b0, irq}, 0);
    // R3 stop both sets, then R9 drop
    wr(8'h08, 32'h1100); wr(8'h18, 32'h1100);
    exp_arm[0] = 0; exp_arm[1] = 0;
    rd(8'h08, d);  chk("R3 set0 stopped", {31'b0, d[15]}, 0);
    rd(8'h18, d);  chk("R3 set1 stopped", {31'b0, d[15]}, 0);
    run_frame(20);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule